// File: doc/BRIEF.md
# Delayed Read Retry Matcher

This block sits on the downstream side of a bus bridge and keeps one pending delayed memory read. A master that gets retried must repeat its request. The block compares each new request with the entry it holds. It answers with one of three decisions: complete (data is ready and the request matches), retry, or new-request (the entry was empty, so the request has just been captured and a fetch can start). Fetching the data and the bus handshake are handled elsewhere.

Normally a repeated request matches only when its address, byte enables and read kind are all equal to the held entry. A relaxed mode can be switched on. In that mode the three memory read kinds count as interchangeable once data is ready, so any master that repeats the address and byte enables with another read kind is completed. The relaxed mode has no effect while the downstream bus runs in PCI-X mode. All decisions are registered and appear one clock after the request. A granted completion empties the entry on that same edge.

Top module: `drr_matcher`

## Requirements
- R1: A synchronous active-high reset empties the entry and drives dec_valid, dec_code and entry_clear to 0.
- R2: dec_valid is 1 exactly in the cycle after a cycle with req_valid high, and 0 otherwise.
- R3: A request that arrives while the entry is empty is captured and answered with dec_code 3 (new-request), without entry_clear.
- R4: A request with equal address, byte enables and read kind, arriving while cpl_ready is 1, is answered with dec_code 1 (complete). entry_clear is 1 in the same cycle, and the entry is empty afterwards.
- R5: A request that matches while cpl_ready is 0 is answered with dec_code 2 (retry), and the entry is kept.
- R6: A request whose address or byte enables differ from the held entry is answered with dec_code 2 (retry), and the entry is neither replaced nor cleared.
- R7: With relax_en at 0, a request that differs from the entry only in read kind is answered with retry.
- R8: Read kinds are coded 0 plain read, 1 read line, 2 read multiple and 3 reserved. With relax_en 1, pcix_mode 0 and cpl_ready 1, a request with equal address and byte enables whose kind and the entry's kind are both in 0..2 is completed, even when the kinds differ. Kind 3 only ever matches exactly.
- R9: While pcix_mode is 1, relax_en has no effect and the read kind must match exactly.
- R10: entry_clear is 1 only together with a complete decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read request is present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_be | input | BE_W | Request byte enables |
| req_kind | input | 2 | Read kind: 0 plain, 1 line, 2 multiple, 3 reserved |
| cpl_ready | input | 1 | Data for the held entry has been obtained |
| relax_en | input | 1 | Allows a change of read kind to match |
| pcix_mode | input | 1 | Downstream bus runs in PCI-X mode |
| dec_valid | output | 1 | Decision present |
| dec_code | output | 2 | 1 complete, 2 retry, 3 new-request |
| entry_clear | output | 1 | Held entry emptied by this completion |

## Verification
The hardest state to reach is an occupied entry whose stored kind differs from the probe's kind while the relax enable, the bus-mode flag and the data-ready flag each take either value. Each case needs the entry first loaded through an ordinary request. The bench therefore sweeps every stored kind against every probe kind, together with address and byte-enable equality, ready, relax enable and bus mode. Every case begins by loading the entry. Any case that does not complete then replays the stored request, which proves the entry survived intact and empties it for the next case.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_LINE  = 2'd1,
    KIND_MULTI = 2'd2,
    KIND_RSVD  = 2'd3
  } drr_kind_e;

  typedef enum logic [1:0] {
    DEC_NONE     = 2'd0,
    DEC_COMPLETE = 2'd1,
    DEC_RETRY    = 2'd2,
    DEC_NEWREQ   = 2'd3
  } drr_dec_e;
endpackage

// File: rtl/drr_entry.sv
module drr_entry #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic [1:0]        in_kind,
  output logic              vld,
  output logic [ADDR_W-1:0] addr,
  output logic [BE_W-1:0]   be,
  output logic [1:0]        kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      addr <= '0;
      be   <= '0;
      kind <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      addr <= in_addr;
      be   <= in_be;
      kind <= in_kind;
    end else if (clear) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/drr_compare.sv
module drr_compare
  import drr_pkg::*;
#(
  parameter int  ADDR_W    = 32,
  parameter int  BE_W      = 4,
  parameter bit  HAS_RELAX = 1'b1
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [BE_W-1:0]   a_be,
  input  logic [1:0]        a_kind,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [BE_W-1:0]   b_be,
  input  logic [1:0]        b_kind,
  input  logic              relax_allowed,
  output logic              hit
);
  logic addr_eq, be_eq, kind_eq, kind_ok;

  assign addr_eq = (a_addr == b_addr);
  assign be_eq   = (a_be == b_be);
  assign kind_eq = (a_kind == b_kind);

  generate
    if (HAS_RELAX) begin : g_relax
      logic both_reads;
      assign both_reads = (a_kind != KIND_RSVD) && (b_kind != KIND_RSVD);
      assign kind_ok    = kind_eq || (relax_allowed && both_reads);
    end else begin : g_strict
      logic unused_relax;
      assign unused_relax = relax_allowed;
      assign kind_ok      = kind_eq;
    end
  endgenerate

  assign hit = addr_eq && be_eq && kind_ok;
endmodule

// File: rtl/drr_decide.sv
module drr_decide
  import drr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       ent_vld,
  input  logic       hit,
  input  logic       cpl_ready,
  output logic       load,
  output logic       clear,
  output logic       dec_valid,
  output drr_dec_e   dec_code,
  output logic       entry_clear
);
  drr_dec_e next_code;

  always_comb begin
    load      = 1'b0;
    clear     = 1'b0;
    next_code = DEC_NONE;
    if (req_valid) begin
      if (!ent_vld) begin
        load      = 1'b1;
        next_code = DEC_NEWREQ;
      end else if (hit && cpl_ready) begin
        clear     = 1'b1;
        next_code = DEC_COMPLETE;
      end else begin
        next_code = DEC_RETRY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_code    <= DEC_NONE;
      entry_clear <= 1'b0;
    end else begin
      dec_valid   <= req_valid;
      dec_code    <= next_code;
      entry_clear <= clear;
    end
  end
endmodule

// File: rtl/drr_matcher.sv
module drr_matcher
  import drr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BE_W      = 4,
  parameter bit HAS_RELAX = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [1:0]        req_kind,
  input  logic              cpl_ready,
  input  logic              relax_en,
  input  logic              pcix_mode,
  output logic              dec_valid,
  output logic [1:0]        dec_code,
  output logic              entry_clear
);
  logic              ent_vld;
  logic [ADDR_W-1:0] ent_addr;
  logic [BE_W-1:0]   ent_be;
  logic [1:0]        ent_kind;
  logic              load, clear, hit, relax_allowed;
  drr_dec_e          code_q;

  assign relax_allowed = relax_en && !pcix_mode;

  drr_entry #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_entry (
    .clk(clk), .rst(rst), .load(load), .clear(clear),
    .in_addr(req_addr), .in_be(req_be), .in_kind(req_kind),
    .vld(ent_vld), .addr(ent_addr), .be(ent_be), .kind(ent_kind)
  );

  drr_compare #(.ADDR_W(ADDR_W), .BE_W(BE_W), .HAS_RELAX(HAS_RELAX)) u_cmp (
    .a_addr(ent_addr), .a_be(ent_be), .a_kind(ent_kind),
    .b_addr(req_addr), .b_be(req_be), .b_kind(req_kind),
    .relax_allowed(relax_allowed), .hit(hit)
  );

  drr_decide u_dec (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ent_vld(ent_vld),
    .hit(hit), .cpl_ready(cpl_ready), .load(load), .clear(clear),
    .dec_valid(dec_valid), .dec_code(code_q), .entry_clear(entry_clear)
  );

  assign dec_code = code_q;
endmodule

// File: rtl/drr_matcher_chk.sv
module drr_matcher_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              pcix_mode,
  input logic              dec_valid,
  input logic [1:0]        dec_code,
  input logic              entry_clear,
  input logic              ent_vld,
  input logic [ADDR_W-1:0] ent_addr,
  input logic [BE_W-1:0]   ent_be,
  input logic [1:0]        ent_kind
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R10
  clear_with_complete_chk: assert property (@(posedge clk) disable iff (rst)
    entry_clear |-> (dec_valid && dec_code == 2'd1));

  // R2
  decision_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (dec_valid == $past(req_valid)));

  // R3
  newreq_only_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && dec_valid && dec_code == 2'd3) |-> (!$past(ent_vld) && ent_vld));

  // R4
  complete_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_code == 2'd1) |-> !ent_vld);

  // R6
  retry_keeps_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && dec_valid && dec_code == 2'd2) |->
      (ent_vld && ent_addr == $past(ent_addr) && ent_be == $past(ent_be)
       && ent_kind == $past(ent_kind)));

  // R9
  pcix_strict_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && dec_valid && dec_code == 2'd1 && $past(pcix_mode)) |->
      ($past(req_kind) == $past(ent_kind)));
endmodule

bind drr_matcher drr_matcher_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .pcix_mode(pcix_mode), .dec_valid(dec_valid), .dec_code(dec_code),
  .entry_clear(entry_clear), .ent_vld(ent_vld), .ent_addr(ent_addr),
  .ent_be(ent_be), .ent_kind(ent_kind)
);

// File: tb/drr_matcher_test.sv
`timescale 1ns/1ps
module drr_matcher_test;
  localparam int AW = 4;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_be = '0;
  logic [1:0] req_kind = '0;
  logic cpl_ready = 1'b0, relax_en = 1'b0, pcix_mode = 1'b0;
  logic dec_valid, entry_clear;
  logic [1:0] dec_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drr_matcher #(.ADDR_W(AW), .BE_W(BW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_kind(req_kind), .cpl_ready(cpl_ready),
    .relax_en(relax_en), .pcix_mode(pcix_mode), .dec_valid(dec_valid),
    .dec_code(dec_code), .entry_clear(entry_clear)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one request, return the decision seen one clock later.
  task automatic send(input logic [AW-1:0] a, input logic [BW-1:0] b,
                      input logic [1:0] k, input logic rdy,
                      input logic [1:0] exp_code, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be = b; req_kind = k; cpl_ready = rdy;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " dec_valid (R2)"}, {3'b0, dec_valid}, 4'h1);
    check({tag, " code"}, {2'b0, dec_code}, {2'b0, exp_code});
    check({tag, " clear (R10)"}, {3'b0, entry_clear}, {3'b0, exp_code == 2'd1});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] A;
    logic [BW-1:0] B;
    A = 4'h6; B = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 dec_valid", {3'b0, dec_valid}, 4'h0);
    check("R1 code", {2'b0, dec_code}, 4'h0);
    check("R1 clear", {3'b0, entry_clear}, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle", {3'b0, dec_valid}, 4'h0);
    // R3 load, R5 retry while not ready, R4 complete
    send(A, B, 2'd0, 1'b0, 2'd3, "R3 load");
    send(A, B, 2'd0, 1'b0, 2'd2, "R5 not ready");
    send(A, B, 2'd0, 1'b1, 2'd1, "R4 exact");
    send(A, B, 2'd0, 1'b1, 2'd3, "R4 emptied");
    // R1 reset empties the entry
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send(A, B, 2'd1, 1'b1, 2'd3, "R1 empty after reset");
    send(A, B, 2'd1, 1'b1, 2'd1, "R4 drain");

    // sweep
    for (int sp = 0; sp < 2; sp++)
      for (int px = 0; px < 2; px++)
        for (int lk = 0; lk < 4; lk++)
          for (int nk = 0; nk < 4; nk++)
            for (int am = 0; am < 2; am++)
              for (int bm = 0; bm < 2; bm++)
                for (int rd = 0; rd < 2; rd++) begin
                  logic kind_ok, hit;
                  logic [1:0] expc;
                  string tag;
                  relax_en = sp[0]; pcix_mode = px[0];
                  kind_ok = (lk == nk) ||
                            (sp == 1 && px == 0 && lk < 3 && nk < 3);
                  hit = (am == 1) && (bm == 1) && kind_ok && (rd == 1);
                  expc = hit ? 2'd1 : 2'd2;
                  if (am == 0 || bm == 0) tag = "R6 mismatch";
                  else if (lk == nk) tag = (rd == 1) ? "R4 exact" : "R5 not ready";
                  else if (px == 1) tag = "R9 pcix strict";
                  else if (sp == 0) tag = "R7 strict";
                  else tag = "R8 relaxed";
                  send(A, B, lk[1:0], 1'b0, 2'd3, "R3 sweep load");
                  send(am ? A : A ^ 4'h1, bm ? B : B ^ 2'b01, nk[1:0],
                       rd[0], expc, tag);
                  if (!hit)
                    send(A, B, lk[1:0], 1'b1, 2'd1, "R6 entry kept");
                  @(negedge clk);
                  check("R2 no request", {3'b0, dec_valid}, 4'h0);
                end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule